// File: doc/BRIEF.md
# Video Line-Lock Hysteresis Detector

This block decides whether a video decoder's timing recovery should be reported as locked. Once per video line, marked by a one-cycle line strobe, it looks at two raw indicators from upstream loops: horizontal-sync lock and colour-subcarrier lock. An enable input chooses whether subcarrier lock takes part. When it is off, only horizontal-sync lock matters. When it is on, both indicators must be set.

The block applies hysteresis in units of lines, not clock cycles. While unlocked, it counts consecutive lines on which the condition holds, and declares lock once that run reaches the entry length. While locked, it counts consecutive lines on which the condition fails, and drops lock once that run reaches the exit length. Each length is picked by its own 3-bit code from a fixed nonlinear table that spans 1 to 100000 lines. A line that breaks the run restarts the count. Changing either code also restarts the count.

Top module: `line_lock_filter`

## Requirements
- R1: After reset, `locked` is 0 and `lockStatus` is 2'b00.
- R2: The line condition is `hsLockRaw` when `scLockEn` is 0, and `hsLockRaw & scLockRaw` when `scLockEn` is 1. `lockStatus[1]` holds the condition sampled on the most recent strobed line.
- R3: `entrySel` selects the entry run length as follows: code 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000 and 7→100000 lines.
- R4: `exitSel` selects the exit run length from the same table, independently of `entrySel`.
- R5: While unlocked, `locked` rises at the clock edge of the Nth consecutive strobed line whose condition is 1, where N is the entry length. A line whose condition is 0 restarts the run.
- R6: While locked, `locked` falls at the clock edge of the Mth consecutive strobed line whose condition is 0, where M is the exit length. A line whose condition is 1 restarts the run.
- R7: Cycles with `lineStb` low do not advance or clear the run, and do not change either output.
- R8: A change of `entrySel` or `exitSel` restarts the run. A strobe in the same cycle as the change is not counted.
- R9: `lockStatus[0]` equals `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStb | input | 1 | One pulse per video line; samples the raw flags |
| hsLockRaw | input | 1 | Raw horizontal-sync lock |
| scLockRaw | input | 1 | Raw colour-subcarrier lock |
| scLockEn | input | 1 | 1: subcarrier lock is part of the condition |
| entrySel | input | 3 | Code for the lines needed to enter lock |
| exitSel | input | 3 | Code for the lines needed to leave lock |
| locked | output | 1 | Registered lock decision |
| lockStatus | output | 2 | Bit 1: last line condition; bit 0: lock decision |

## Verification
The bench goes after off-by-one errors in each table entry. For every code, in both directions, it checks that the state has not yet changed one line before the target and has changed exactly at the target. A counter compared against the length instead of the length minus one would switch one line late, and a misordered table would switch at the wrong code. Runs are broken one line short of completion to catch a counter that is not cleared, which would lock early. Idle gaps are placed inside a pending run to expose logic that counts clock cycles instead of lines. A code change is made mid-run to catch a stale count carried across. The enable input is exercised with each raw flag alone, so that a gate on the wrong flag shows up in both output bits. The 100000-line code is run in full to check the widest count.

// File: rtl/llf_pkg.sv
package llf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic clr;
  } cntCtl_t;

  localparam int unsigned TGT_W = 32;

  // Run length in lines for a 3-bit select code
  function automatic logic [TGT_W-1:0] linesForCode(input logic [2:0] code);
    logic [TGT_W-1:0] n;
    case (code)
      3'd0:    n = 32'd1;
      3'd1:    n = 32'd2;
      3'd2:    n = 32'd5;
      3'd3:    n = 32'd10;
      3'd4:    n = 32'd100;
      3'd5:    n = 32'd500;
      3'd6:    n = 32'd1000;
      default: n = 32'd100000;
    endcase
    return n;
  endfunction

  localparam logic [TGT_W-1:0] MAX_LINES = 32'd100000;

endpackage

// File: rtl/llf_datapath.sv
module llf_datapath
  import llf_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctl,
  input  logic             useExit,
  input  logic [SEL_W-1:0] entrySel,
  input  logic [SEL_W-1:0] exitSel,
  output logic             hitNext
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] cntPlus;
  logic [TGT_W-1:0] target;
  logic [TGT_W-1:0] cntPlusWide;

  always_comb begin
    target      = useExit ? linesForCode(3'(exitSel)) : linesForCode(3'(entrySel));
    cntPlus     = (runCnt == CNT_MAX) ? runCnt : runCnt + 1'b1;
    cntPlusWide = TGT_W'(cntPlus);
    hitNext     = (cntPlusWide >= target);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         runCnt <= '0;
    else if (ctl.clr)  runCnt <= '0;
    else if (ctl.inc)  runCnt <= cntPlus;
  end

  // R5 R6: the run is cleared on reaching its length, so it stays below the largest one
  cnt_below_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    TGT_W'(runCnt) < MAX_LINES);

  // R8
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (runCnt == '0));

endmodule

// File: rtl/llf_ctrl.sv
module llf_ctrl
  import llf_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStb,
  input  logic             hsLockRaw,
  input  logic             scLockRaw,
  input  logic             scLockEn,
  input  logic [SEL_W-1:0] entrySel,
  input  logic [SEL_W-1:0] exitSel,
  input  logic             hitNext,
  output cntCtl_t          ctl,
  output logic             lockState,
  output logic             condLast
);

  logic             lineCond;
  logic             pending;
  logic             selChg;
  logic             flip;
  logic [SEL_W-1:0] entryPrev;
  logic [SEL_W-1:0] exitPrev;

  always_comb begin
    lineCond = hsLockRaw & (scLockRaw | ~scLockEn);
    pending  = lockState ? ~lineCond : lineCond;
    selChg   = (entrySel != entryPrev) || (exitSel != exitPrev);
    flip     = lineStb & pending & hitNext & ~selChg;
    ctl.clr  = selChg | (lineStb & (~pending | hitNext));
    ctl.inc  = lineStb & pending & ~hitNext & ~selChg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= 1'b0;
      condLast  <= 1'b0;
      entryPrev <= '0;
      exitPrev  <= '0;
    end else begin
      entryPrev <= entrySel;
      exitPrev  <= exitSel;
      if (flip)    lockState <= ~lockState;
      if (lineStb) condLast  <= lineCond;
    end
  end

  // R7
  idle_holds_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineStb |=> ($stable(lockState) && $stable(condLast)));

  // R5
  lock_needs_good_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockState) |-> $past(lineStb && lineCond));

  // R6
  unlock_needs_bad_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockState) |-> $past(lineStb && !lineCond));

  // R8
  sel_change_blocks_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    selChg |=> $stable(lockState));

endmodule

// File: rtl/line_lock_filter.sv
module line_lock_filter
  import llf_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStb,
  input  logic             hsLockRaw,
  input  logic             scLockRaw,
  input  logic             scLockEn,
  input  logic [SEL_W-1:0] entrySel,
  input  logic [SEL_W-1:0] exitSel,
  output logic             locked,
  output logic [1:0]       lockStatus
);

  cntCtl_t ctl;
  logic    hitNext;
  logic    lockState;
  logic    condLast;

  llf_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .lineStb(lineStb),
    .hsLockRaw(hsLockRaw), .scLockRaw(scLockRaw), .scLockEn(scLockEn),
    .entrySel(entrySel), .exitSel(exitSel), .hitNext(hitNext),
    .ctl(ctl), .lockState(lockState), .condLast(condLast)
  );

  llf_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .useExit(lockState),
    .entrySel(entrySel), .exitSel(exitSel), .hitNext(hitNext)
  );

  assign locked     = lockState;
  assign lockStatus = {condLast, lockState};

  // R9
  status_mirrors_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockStatus[0] == locked);

endmodule

// File: tb/line_lock_filter_tb_top.sv
module line_lock_filter_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       lineStb;
  logic       hsLockRaw;
  logic       scLockRaw;
  logic       scLockEn;
  logic [2:0] entrySel;
  logic [2:0] exitSel;
  logic       locked;
  logic [1:0] lockStatus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  line_lock_filter dut_i (
    .clk(clk), .rstN(rstN), .lineStb(lineStb),
    .hsLockRaw(hsLockRaw), .scLockRaw(scLockRaw), .scLockEn(scLockEn),
    .entrySel(entrySel), .exitSel(exitSel),
    .locked(locked), .lockStatus(lockStatus)
  );

  // Run lengths taken from the requirement table, R3 and R4
  function automatic int expLines(input int code);
    int base;
    case (code % 4)
      0: base = 1;
      1: base = 2;
      2: base = 5;
      default: base = 10;
    endcase
    if (code == 4) return 100;
    if (code == 5) return 500;
    if (code == 6) return 1000;
    if (code == 7) return 100000;
    return base;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; strobes n consecutive lines, returns at a negedge
  task automatic runLines(input int n, input logic hs, input logic sc);
    if (n > 0) begin
      hsLockRaw = hs;
      scLockRaw = sc;
      lineStb   = 1'b1;
      repeat (n) @(negedge clk);
      lineStb   = 1'b0;
    end
  endtask

  task automatic setSel(input int e, input int x);
    entrySel = 3'(e);
    exitSel  = 3'(x);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; lineStb = 1'b0; hsLockRaw = 1'b0; scLockRaw = 1'b0;
    scLockEn = 1'b0; entrySel = 3'd0; exitSel = 3'd0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1
    chk(locked == 1'b0, "R1 locked after reset", int'(locked), 0);
    chk(lockStatus == 2'b00, "R1 status after reset", int'(lockStatus), 0);

    // R3 R4 R5 R6: sweep codes 0..6 for entry and exit
    for (int c = 0; c < 7; c++) begin
      int n;
      n = expLines(c);
      setSel(c, 0);
      runLines(n - 1, 1'b1, 1'b0);
      chk(locked == 1'b0, $sformatf("R3 entry code %0d early", c), int'(locked), 0);
      runLines(1, 1'b1, 1'b0);
      chk(locked == 1'b1, $sformatf("R3 entry code %0d at target", c), int'(locked), 1);
      chk(lockStatus == 2'b11, "R9 R2 status when locked", int'(lockStatus), 3);
      setSel(c, c);
      runLines(n - 1, 1'b0, 1'b1);
      chk(locked == 1'b1, $sformatf("R4 exit code %0d early", c), int'(locked), 1);
      runLines(1, 1'b0, 1'b1);
      chk(locked == 1'b0, $sformatf("R4 exit code %0d at target", c), int'(locked), 0);
      chk(lockStatus == 2'b00, "R9 R2 status when unlocked", int'(lockStatus), 0);
    end

    // R5: broken run restarts (entry 10 lines)
    setSel(3, 0);
    runLines(5, 1'b1, 1'b0);
    runLines(1, 1'b0, 1'b0);
    runLines(9, 1'b1, 1'b0);
    chk(locked == 1'b0, "R5 run restarted after bad line", int'(locked), 0);
    runLines(1, 1'b1, 1'b0);
    chk(locked == 1'b1, "R5 lock after fresh run", int'(locked), 1);

    // R6: broken exit run restarts (exit 10 lines)
    setSel(3, 3);
    runLines(5, 1'b0, 1'b0);
    runLines(1, 1'b1, 1'b0);
    runLines(9, 1'b0, 1'b0);
    chk(locked == 1'b1, "R6 exit run restarted after good line", int'(locked), 1);
    chk(lockStatus[1] == 1'b0, "R2 last condition bad", int'(lockStatus[1]), 0);
    runLines(1, 1'b0, 1'b0);
    chk(locked == 1'b0, "R6 unlock after fresh run", int'(locked), 0);

    // R7: idle cycles neither count nor clear (entry 5 lines)
    setSel(2, 0);
    runLines(4, 1'b1, 1'b0);
    for (int i = 0; i < 50; i++) begin
      hsLockRaw = i[0];
      @(negedge clk);
    end
    chk(locked == 1'b0, "R7 idle cycles did not count", int'(locked), 0);
    chk(lockStatus[1] == 1'b1, "R7 status held over idle", int'(lockStatus[1]), 1);
    runLines(1, 1'b1, 1'b0);
    chk(locked == 1'b1, "R7 idle cycles did not clear", int'(locked), 1);
    runLines(1, 1'b0, 1'b0);
    chk(locked == 1'b0, "R6 exit code 0 single line", int'(locked), 0);

    // R8: changing a code mid-run restarts it (entry 10 lines)
    setSel(3, 0);
    runLines(9, 1'b1, 1'b0);
    setSel(3, 1);
    runLines(9, 1'b1, 1'b0);
    chk(locked == 1'b0, "R8 code change restarted run", int'(locked), 0);
    runLines(1, 1'b1, 1'b0);
    chk(locked == 1'b1, "R8 lock after restarted run", int'(locked), 1);
    runLines(2, 1'b0, 1'b0);
    chk(locked == 1'b0, "R4 exit code 1 two lines", int'(locked), 0);

    // R2: subcarrier enable
    setSel(0, 0);
    scLockEn = 1'b1;
    runLines(1, 1'b1, 1'b0);
    chk(lockStatus == 2'b00, "R2 enable on, hs only", int'(lockStatus), 0);
    runLines(1, 1'b0, 1'b1);
    chk(lockStatus == 2'b00, "R2 enable on, sc only", int'(lockStatus), 0);
    runLines(1, 1'b1, 1'b1);
    chk(lockStatus == 2'b11, "R2 enable on, both", int'(lockStatus), 3);
    runLines(1, 1'b1, 1'b0);
    chk(lockStatus == 2'b00, "R2 enable on, sc lost unlocks", int'(lockStatus), 0);
    scLockEn = 1'b0;
    runLines(1, 1'b1, 1'b0);
    chk(lockStatus == 2'b11, "R2 enable off, hs only locks", int'(lockStatus), 3);
    runLines(1, 1'b0, 1'b1);
    chk(lockStatus == 2'b00, "R2 enable off, sc ignored", int'(lockStatus), 0);

    // R3: widest code, 100000 lines
    setSel(7, 0);
    runLines(expLines(7) - 1, 1'b1, 1'b0);
    chk(locked == 1'b0, "R3 entry code 7 early", int'(locked), 0);
    runLines(1, 1'b1, 1'b0);
    chk(locked == 1'b1, "R3 entry code 7 at target", int'(locked), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule